// File: doc/BRIEF.md
# SPI Flash Execute-in-Place Page Cache

This block lets a small processor fetch instructions straight out of a serial NOR flash. It sits on the processor's byte-wide instruction-fetch port and holds one page of flash content (256 bytes by default) in on-chip storage. A fetch whose address lies in the held page is answered in the same cycle from that storage, with no activity on the serial lines.

A fetch outside the held page raises the wait signal in the same cycle as the strobe. The block then drives, with no software involved, a single serial read command for the whole page-aligned region and streams every byte of the page into its storage. The wait signal drops as soon as the byte the processor asked for has landed. The stream always runs to the end of the page, so later fetches in that page hit. The processor holds its strobe and address steady while wait is high.

Top module: `xip_page_cache`

## Requirements
- R1: After reset, `fetch_wait` is low with no strobe, `spi_cs_n` is high and `spi_sck` is low, and the first fetch after reset is treated as a miss.
- R2: A strobe whose address lies in the fully or partly loaded page, at an offset already written, sees `fetch_wait` low in the same cycle and the correct flash byte on `fetch_data`; it starts no serial transaction.
- R3: A strobe that misses sees `fetch_wait` high in the same cycle; a serial transaction begins only after such a cycle.
- R4: Each refill is one chip-select-low window holding exactly 8 + 24 + 8·256 SCK rising edges.
- R5: The command is the byte 0x03 followed by a 24-bit address, both most significant bit first; the address equals the fetch address with bits [7:0] forced to zero.
- R6: SPI mode 0: SCK rests low while chip select is high, MOSI does not change while SCK is high, and the flash drives read data most significant bit first, sampled on the rising SCK edge.
- R7: During a refill, `fetch_wait` falls once the requested byte is stored, while chip select is still low if that byte is not the last one; bytes already stored hit during the rest of the refill.
- R8: One SCK period lasts `CLK_DIV` system clock cycles (default 4).
- R9: After a refill ends, every offset of that page hits with correct data.
- R10: A fetch to another page replaces the held page, so a later fetch to the old page misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_addr | input | 24 | Byte address of the instruction fetch |
| fetch_rd | input | 1 | Fetch strobe, held until `fetch_wait` is low |
| fetch_data | output | 8 | Fetched byte, valid when `fetch_rd` is high and `fetch_wait` low |
| fetch_wait | output | 1 | Stall request to the processor |
| spi_sck | output | 1 | Serial clock to the flash |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Command and address bits to the flash |
| spi_miso | input | 1 | Data bits from the flash |

## Verification
Fetches are tried as a cold miss in the middle of a page, as a hit on an offset already streamed in while the refill is still running, as a fetch to the last offset that has to wait for the stream, and as a stride sweep across a finished page. Misses to a neighbouring page, back to a replaced page and to the top page of the address space separate a correct tag compare from one that ignores high address bits or never replaces the page. The flash model, fed a computed content pattern that differs at every offset and page, exposes wrong bit order, wrong byte count, a missing address alignment and a divider mismatch.

// File: rtl/xip_pkg.sv
// Shared constants of the execute-in-place page cache.
// Assumes a flash with 24-bit byte addressing and the plain read command.
package xip_pkg;
    localparam int FLASH_AW   = 24;
    localparam int CMD_BITS   = 8;
    localparam int HDR_BITS   = CMD_BITS + FLASH_AW;
    localparam logic [CMD_BITS-1:0] READ_OPCODE = 8'h03;
endpackage

// File: rtl/xip_spi_reader.sv
// Serial master for one page-long read transaction in SPI mode 0.
// Sends the opcode and a 24-bit address MSB first, then clocks in
// PAGE_BYTES bytes MSB first, reporting each byte with a one-cycle pulse.
// Assumes CLK_DIV >= 2; start is only honoured while not busy.
module xip_spi_reader
    import xip_pkg::*;
#(
    parameter int CLK_DIV    = 4,
    parameter int PAGE_BYTES = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [FLASH_AW-1:0] start_addr,
    output logic                busy,
    output logic                rx_valid,
    output logic [7:0]          rx_byte,
    output logic                spi_sck,
    output logic                spi_cs_n,
    output logic                spi_mosi,
    input  logic                spi_miso
);
    localparam int LOW_CYC    = CLK_DIV / 2;
    localparam int TOTAL_BITS = HDR_BITS + 8 * PAGE_BYTES;
    localparam int BIT_W      = $clog2(TOTAL_BITS + 1);
    localparam int PH_W       = $clog2(CLK_DIV);

    logic [PH_W-1:0]     ph_q;
    logic [BIT_W-1:0]    bit_q;
    logic [HDR_BITS-1:0] out_sr;
    logic [6:0]          in_sr;
    logic                busy_q;
    logic                sck_q;
    logic                cs_q;

    // Sequence one transaction: divider phase, bit count, shift in and out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q     <= '0;
            bit_q    <= '0;
            out_sr   <= '0;
            in_sr    <= '0;
            busy_q   <= 1'b0;
            sck_q    <= 1'b0;
            cs_q     <= 1'b1;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    cs_q   <= 1'b0;
                    out_sr <= {READ_OPCODE, start_addr};
                    ph_q   <= '0;
                    bit_q  <= '0;
                    sck_q  <= 1'b0;
                end
            end else if (ph_q == PH_W'(CLK_DIV - 1)) begin
                ph_q   <= '0;
                sck_q  <= 1'b0;
                out_sr <= {out_sr[HDR_BITS-2:0], 1'b0};
                bit_q  <= bit_q + 1'b1;
                if (bit_q == BIT_W'(TOTAL_BITS - 1)) begin
                    busy_q <= 1'b0;
                    cs_q   <= 1'b1;
                end
            end else begin
                ph_q <= ph_q + 1'b1;
                if (ph_q == PH_W'(LOW_CYC - 1)) begin
                    sck_q <= 1'b1;
                    if (bit_q >= BIT_W'(HDR_BITS)) begin
                        in_sr <= {in_sr[5:0], spi_miso};
                        if (bit_q[2:0] == 3'b111) begin
                            rx_valid <= 1'b1;
                            rx_byte  <= {in_sr, spi_miso};
                        end
                    end
                end
            end
        end
    end

    assign busy     = busy_q;
    assign spi_sck  = sck_q;
    assign spi_cs_n = cs_q;
    assign spi_mosi = out_sr[HDR_BITS-1];
endmodule

// File: rtl/xip_page_ram.sv
// Page storage: one synchronous write port, one combinational read port.
// Assumes a single writer; content is undefined until written.
module xip_page_ram #(
    parameter int PAGE_BITS = 8
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [PAGE_BITS-1:0] wr_idx,
    input  logic [7:0]           wr_data,
    input  logic [PAGE_BITS-1:0] rd_idx,
    output logic [7:0]           rd_data
);
    localparam int DEPTH = 1 << PAGE_BITS;

    logic [7:0] mem_q [DEPTH];

    // Store one streamed byte.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_data;
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/xip_fill_ctrl.sv
// Tag and fill tracking. Holds the page tag and the count of bytes of that
// page already stored; a fetch hits when its tag matches and its offset is
// below the count. A miss seen while the serial master is idle starts a
// refill at the page-aligned address. Assumes the processor holds its
// strobe and address while wait is high.
module xip_fill_ctrl
    import xip_pkg::*;
#(
    parameter int PAGE_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [FLASH_AW-1:0]  fetch_addr,
    input  logic                 fetch_rd,
    output logic                 fetch_wait,
    input  logic                 spi_busy,
    input  logic                 rx_valid,
    output logic                 start,
    output logic [FLASH_AW-1:0]  start_addr,
    output logic                 ram_we,
    output logic [PAGE_BITS-1:0] ram_widx
);
    localparam int TAG_W = FLASH_AW - PAGE_BITS;

    logic [TAG_W-1:0]   tag_q;
    logic [PAGE_BITS:0] fill_q;
    logic [TAG_W-1:0]   req_tag;
    logic               hit;

    // Compare the fetch against the held page and its filled prefix.
    always_comb begin
        req_tag    = fetch_addr[FLASH_AW-1:PAGE_BITS];
        hit        = (req_tag == tag_q) &&
                     ({1'b0, fetch_addr[PAGE_BITS-1:0]} < fill_q);
        fetch_wait = fetch_rd && !hit;
        start      = fetch_rd && !hit && !spi_busy;
        start_addr = {req_tag, {PAGE_BITS{1'b0}}};
    end

    // Retag on a refill start and advance the filled count per byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '0;
            fill_q <= '0;
        end else if (start) begin
            tag_q  <= req_tag;
            fill_q <= '0;
        end else if (rx_valid) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    assign ram_we   = rx_valid;
    assign ram_widx = fill_q[PAGE_BITS-1:0];
endmodule

// File: rtl/xip_page_cache.sv
// Top of the execute-in-place page cache: fetch port on one side, serial
// flash on the other. Hits return in the same cycle; misses stall the
// fetch until the wanted byte arrives from a whole-page read.
module xip_page_cache
    import xip_pkg::*;
#(
    parameter int CLK_DIV   = 4,
    parameter int PAGE_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FLASH_AW-1:0] fetch_addr,
    input  logic                fetch_rd,
    output logic [7:0]          fetch_data,
    output logic                fetch_wait,
    output logic                spi_sck,
    output logic                spi_cs_n,
    output logic                spi_mosi,
    input  logic                spi_miso
);
    localparam int PAGE_BYTES = 1 << PAGE_BITS;

    logic                 start;
    logic [FLASH_AW-1:0]  start_addr;
    logic                 busy;
    logic                 rx_valid;
    logic [7:0]           rx_byte;
    logic                 ram_we;
    logic [PAGE_BITS-1:0] ram_widx;

    xip_fill_ctrl #(.PAGE_BITS(PAGE_BITS)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_addr (fetch_addr),
        .fetch_rd   (fetch_rd),
        .fetch_wait (fetch_wait),
        .spi_busy   (busy),
        .rx_valid   (rx_valid),
        .start      (start),
        .start_addr (start_addr),
        .ram_we     (ram_we),
        .ram_widx   (ram_widx)
    );

    xip_spi_reader #(.CLK_DIV(CLK_DIV), .PAGE_BYTES(PAGE_BYTES)) spi_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .busy       (busy),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .spi_sck    (spi_sck),
        .spi_cs_n   (spi_cs_n),
        .spi_mosi   (spi_mosi),
        .spi_miso   (spi_miso)
    );

    xip_page_ram #(.PAGE_BITS(PAGE_BITS)) ram_i (
        .clk     (clk),
        .wr_en   (ram_we),
        .wr_idx  (ram_widx),
        .wr_data (rx_byte),
        .rd_idx  (fetch_addr[PAGE_BITS-1:0]),
        .rd_data (fetch_data)
    );
endmodule

// File: rtl/xip_page_cache_chk.sv
// Protocol checker for the page cache, bound to the top module.
// Counts SCK rising edges per chip-select window and SCK periods.
module xip_page_cache_chk #(
    parameter int CLK_DIV   = 4,
    parameter int PAGE_BITS = 8
) (
    input logic clk,
    input logic rst_n,
    input logic fetch_rd,
    input logic fetch_wait,
    input logic spi_sck,
    input logic spi_cs_n,
    input logic spi_mosi
);
    localparam int TOTAL = 32 + 8 * (1 << PAGE_BITS);

    logic        sck_d;
    logic        cs_d;
    logic        seen_q;
    logic [15:0] gap_q;
    logic [15:0] edges_q;
    logic        rise;

    assign rise = !spi_cs_n && spi_sck && !sck_d;

    // Track edge count and spacing of SCK inside each window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d   <= 1'b0;
            cs_d    <= 1'b1;
            seen_q  <= 1'b0;
            gap_q   <= '0;
            edges_q <= '0;
        end else begin
            sck_d <= spi_sck;
            cs_d  <= spi_cs_n;
            if (rise) begin
                gap_q   <= 16'd1;
                seen_q  <= 1'b1;
                edges_q <= edges_q + 1'b1;
            end else begin
                if (gap_q != 16'hFFFF) gap_q <= gap_q + 1'b1;
                if (spi_cs_n) seen_q <= 1'b0;
                if (spi_cs_n && cs_d) edges_q <= '0;
            end
        end
    end

    // R6
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R6
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && spi_sck && sck_d) |-> $stable(spi_mosi));

    // R3
    start_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> $past(fetch_rd && fetch_wait));

    // R2
    hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_rd && !fetch_wait && spi_cs_n) |=> spi_cs_n);

    // R4
    refill_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> (edges_q == 16'(TOTAL)));

    // R8
    sck_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && seen_q) |-> (gap_q == 16'(CLK_DIV)));
endmodule

bind xip_page_cache xip_page_cache_chk #(
    .CLK_DIV   (CLK_DIV),
    .PAGE_BITS (PAGE_BITS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_rd   (fetch_rd),
    .fetch_wait (fetch_wait),
    .spi_sck    (spi_sck),
    .spi_cs_n   (spi_cs_n),
    .spi_mosi   (spi_mosi)
);

// File: tb/xip_page_cache_test.sv
// Scoreboard bench with a behavioural serial flash model.
module xip_page_cache_test;
    localparam int CLK_DIV = 4;
    localparam int TOTAL   = 32 + 8 * 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] fetch_addr = '0;
    logic        fetch_rd = 1'b0;
    logic [7:0]  fetch_data;
    logic        fetch_wait;
    logic        spi_sck;
    logic        spi_cs_n;
    logic        spi_mosi;
    logic        spi_miso = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    xip_page_cache #(.CLK_DIV(CLK_DIV), .PAGE_BITS(8)) uut (
        .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_rd(fetch_rd),
        .fetch_data(fetch_data), .fetch_wait(fetch_wait), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    function automatic logic [7:0] flash_byte(input logic [23:0] a);
        return (a[7:0] ^ a[15:8]) + (a[23:16] * 8'd3) + 8'h11;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Flash model
    logic [31:0] hdr = '0;
    int          fl_bits = 0;
    int          tx_count = 0;
    logic [7:0]  last_op = '0;
    logic [23:0] last_addr = '0;
    time         t_rise = 0;

    always @(negedge spi_cs_n) begin
        fl_bits = 0;
        if (rst_n) check(spi_sck == 1'b0, "R6", "SCK level at select", spi_sck, 0);
    end

    always @(posedge spi_sck) if (!spi_cs_n) begin
        if (fl_bits == 1)
            check((($time - t_rise) == 20 * CLK_DIV), "R8", "SCK period ns",
                  int'($time - t_rise), 20 * CLK_DIV);
        t_rise = $time;
        if (fl_bits < 32) hdr = {hdr[30:0], spi_mosi};
        fl_bits++;
        if (fl_bits == 32) begin
            last_op   = hdr[31:24];
            last_addr = hdr[23:0];
        end
    end

    always @(negedge spi_sck) if (!spi_cs_n && fl_bits >= 32) begin
        int          k;
        logic [7:0]  b;
        k = fl_bits - 32;
        b = flash_byte(last_addr + 24'(k / 8));
        spi_miso = b[7 - (k % 8)];   // R6: MSB first
    end

    always @(posedge spi_cs_n) if (rst_n) begin
        tx_count++;
        check(fl_bits == TOTAL, "R4", "SCK edges in window", fl_bits, TOTAL);
        check(last_op == 8'h03, "R5", "opcode", last_op, 8'h03);
        check(last_addr[7:0] == 8'h00, "R5", "address low byte", last_addr[7:0], 0);
    end

    // Scoreboard
    logic [7:0] exp_q[$];
    string      req_q[$];

    always @(negedge clk) if (rst_n && fetch_rd && !fetch_wait) begin
        if (exp_q.size() == 0) begin
            check(1'b0, "R2", "unexpected completion", fetch_data, 0);
        end else begin
            logic [7:0] e;
            string      r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            check(fetch_data == e, r, "fetch data", fetch_data, e);
        end
    end

    task automatic fetch(input logic [23:0] a, input int exp_miss, input string req,
                         output logic cs_at_release);
        bit first;
        @(posedge clk);
        #2;
        fetch_addr = a;
        fetch_rd   = 1'b1;
        exp_q.push_back(flash_byte(a));
        req_q.push_back(req);
        first = 1'b1;
        do begin
            @(negedge clk);
            if (first && exp_miss >= 0)
                check(int'(fetch_wait) == exp_miss, "R3", "wait on strobe cycle",
                      fetch_wait, exp_miss);
            first = 1'b0;
        end while (fetch_wait);
        cs_at_release = spi_cs_n;
        @(posedge clk);
        #2;
        fetch_rd = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!spi_cs_n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "R1", "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic cs_rel;
        repeat (5) @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(negedge clk);
        check(fetch_wait == 1'b0, "R1", "wait after reset", fetch_wait, 0);
        check(spi_cs_n == 1'b1, "R1", "select after reset", spi_cs_n, 1);
        check(spi_sck == 1'b0, "R1", "SCK after reset", spi_sck, 0);

        // R1: cold miss mid-page; R7: early release while streaming
        fetch(24'h012345, 1, "R1", cs_rel);
        check(cs_rel == 1'b0, "R7", "select low at release", cs_rel, 0);
        check(tx_count == 0, "R7", "refill still running", tx_count, 0);
        fetch(24'h012300, 0, "R7", cs_rel);
        check(cs_rel == 1'b0, "R7", "hit during refill", cs_rel, 0);
        fetch(24'h0123FF, -1, "R7", cs_rel);
        wait_idle();
        check(tx_count == 1, "R4", "one command per refill", tx_count, 1);
        check(last_addr == 24'h012300, "R5", "refill address", last_addr, 24'h012300);

        // R9: sweep the finished page, R2: no serial traffic
        for (int i = 0; i < 256; i += 15) fetch(24'h012300 + 24'(i), 0, "R9", cs_rel);
        fetch(24'h0123FF, 0, "R9", cs_rel);
        check(tx_count == 1, "R2", "no command on hits", tx_count, 1);

        // R10: neighbouring page, then back to replaced page
        fetch(24'h0124FF, 1, "R10", cs_rel);
        wait_idle();
        check(last_addr == 24'h012400, "R10", "new page address", last_addr, 24'h012400);
        fetch(24'h012345, 1, "R10", cs_rel);
        wait_idle();
        check(tx_count == 3, "R10", "refill count", tx_count, 3);

        // R5: top page of the address space
        fetch(24'hFFFF80, 1, "R5", cs_rel);
        wait_idle();
        check(last_addr == 24'hFFFF00, "R5", "top page address", last_addr, 24'hFFFF00);
        fetch(24'hFFFF00, 0, "R2", cs_rel);
        check(tx_count == 4, "R2", "refill count", tx_count, 4);
        check(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule